// File: doc/BRIEF.md
# Segmented Byte-Lane Memory Access Unit

This unit sits between an execution core and a 16-bit memory bus with a 20-bit byte address. The core presents a segment and an offset along with read/write, byte/word size and write data. The unit forms the physical address by shifting the segment left by four bits and adding the offset, keeping 20 bits. It then runs one or two bus cycles and steers each byte onto the correct half of the data bus. An even byte address uses bits 7..0 and an odd byte address uses bits 15..8.

The memory is organised as two byte banks. Address bit 0 low selects the even bank. A separate active-low high-byte enable selects the odd bank. A word at an even address moves in a single bus cycle. A word at an odd address is split into two byte cycles. Little-endian order is kept: the low byte sits at the lower address. Read results are reassembled and returned with a one-clock completion pulse. A request is accepted only while the unit is idle.

Top module: `seg_mem_unit`

## Requirements
- R1: The bus address of the first cycle equals (segment × 16 + offset) modulo 2^20. The second cycle of a split access uses that address plus one, also modulo 2^20 (0xFFFFF is followed by 0x00000).
- R2: A byte access at an even address takes one bus cycle with address bit 0 = 0 and `bus_bhe_n_o` = 1. A write drives the byte on data bits 7..0 and copies it onto bits 15..8. A read returns bus bits 7..0 in result bits 7..0, with bits 15..8 zero.
- R3: A byte access at an odd address takes one bus cycle with address bit 0 = 1 and `bus_bhe_n_o` = 0. A write drives the byte on data bits 15..8 and copies it onto bits 7..0. A read moves bus bits 15..8 down into result bits 7..0, with bits 15..8 zero.
- R4: A word access at an even address takes one bus cycle with `bus_bhe_n_o` = 0. Write data bits 7..0 go to the even byte address and bits 15..8 to the odd one. The read result is the bus word unchanged.
- R5: A word access at an odd address takes two bus cycles. The first is at the odd address with `bus_bhe_n_o` = 0 and carries data bits 7..0 on bus bits 15..8. The second is at the next, even address with `bus_bhe_n_o` = 1 and carries data bits 15..8 on bus bits 7..0. The read result is {second cycle bus bits 7..0, first cycle bus bits 15..8}.
- R6: Each strobe (`bus_rd_o` or `bus_wr_o`) lasts exactly one clock. The first strobe appears in the cycle after the request is accepted. Read data is taken from `bus_rdata_i` in the cycle after a read strobe. `done_o` is a one-clock pulse two cycles after the final strobe. A single-cycle access therefore completes on the third cycle after acceptance, and a split access on the fifth.
- R7: `busy_o` is high from the cycle after acceptance until the completion cycle, and is low in the completion cycle. A request raised while `busy_o` is high is ignored: it produces no bus cycle and no completion.
- R8: `bus_rd_o` and `bus_wr_o` are never high together. Reads drive only `bus_rd_o` and writes drive only `bus_wr_o`. `rdata_o` is zero after a write completes.
- R9: After reset, no strobe is active and `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = word, 0 = byte |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset within segment |
| wdata_i | input | 16 | Write data (byte in bits 7..0) |
| bus_addr_o | output | 20 | Physical byte address |
| bus_bhe_n_o | output | 1 | Active-low odd-bank enable |
| bus_wdata_o | output | 16 | Lane-steered write data |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_rdata_i | input | 16 | Read data from memory, valid the cycle after a read strobe |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Assembled read result, valid with done_o |
| busy_o | output | 1 | Access in progress |

## Verification
The hardest case to reach from the ports is a request arriving in the middle of a split odd-address word access. That request must leave no trace. The stimulus starts a two-cycle word read at an odd address and pulses a byte write request during the capture cycle between the two strobes. It then confirms that only two read strobes occur, that the reassembled word is correct, and that a later read of the write's target returns the old value. The segment wrap is reached by a word read at 0xFFFFF, whose second cycle must land on 0x00000.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE1,
        ST_CAPT1,
        ST_ISSUE2,
        ST_CAPT2
    } acc_state_t;

    // how the bytes of one bus cycle are placed or gathered
    typedef enum logic [1:0] {
        LK_BYTE,
        LK_WORD,
        LK_SPLIT_LO,
        LK_SPLIT_HI
    } lane_kind_t;

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] phys_o
);
    logic [ADDR_W-1:0] seg_ext;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        seg_ext = ADDR_W'(seg_i) << SHIFT;
        off_ext = ADDR_W'(off_i);
        phys_o  = seg_ext + off_ext;   // carry out of the top bit is dropped
    end
endmodule

// File: rtl/lane_wr_steer.sv
module lane_wr_steer
    import seg_mem_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  lane_kind_t          kind_i,
    input  logic [2*LANE_W-1:0] data_i,
    output logic [2*LANE_W-1:0] bus_o
);
    logic [LANE_W-1:0] lo_b;
    logic [LANE_W-1:0] hi_b;

    always_comb begin
        lo_b = data_i[LANE_W-1:0];
        hi_b = data_i[2*LANE_W-1:LANE_W];
        unique case (kind_i)
            LK_WORD:     bus_o = data_i;
            LK_SPLIT_HI: bus_o = {hi_b, hi_b};
            default:     bus_o = {lo_b, lo_b};   // byte or first half of split
        endcase
    end
endmodule

// File: rtl/lane_rd_merge.sv
module lane_rd_merge
    import seg_mem_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  lane_kind_t          kind_i,
    input  logic                odd_i,
    input  logic [2*LANE_W-1:0] bus_i,
    input  logic [LANE_W-1:0]   saved_lo_i,
    output logic [2*LANE_W-1:0] result_o
);
    logic [LANE_W-1:0] bus_lo;
    logic [LANE_W-1:0] bus_hi;

    always_comb begin
        bus_lo = bus_i[LANE_W-1:0];
        bus_hi = bus_i[2*LANE_W-1:LANE_W];
        unique case (kind_i)
            LK_WORD:     result_o = bus_i;
            LK_SPLIT_HI: result_o = {bus_lo, saved_lo_i};
            LK_BYTE:     result_o = {{LANE_W{1'b0}}, (odd_i ? bus_hi : bus_lo)};
            default:     result_o = '0;
        endcase
    end
endmodule

// File: rtl/seg_mem_unit.sv
module seg_mem_unit
    import seg_mem_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int LANE_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic              word_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_bhe_n_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);

    typedef struct packed {
        acc_state_t        st;
        logic [ADDR_W-1:0] addr;
        logic              bhe_n;
        logic [DATA_W-1:0] bwd;
        logic              rd;
        logic              wr;
        logic              we;
        logic              word;
        logic              odd;
        logic [DATA_W-1:0] wd;
        logic [LANE_W-1:0] lo;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } acc_regs_t;

    acc_regs_t         r_d;
    acc_regs_t         r_q;

    logic [ADDR_W-1:0] phys;
    lane_kind_t        wr_kind;
    logic [DATA_W-1:0] wr_src;
    logic [DATA_W-1:0] wr_lanes;
    lane_kind_t        rd_kind;
    logic [DATA_W-1:0] rd_result;
    logic              split_q;

    seg_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .ADDR_W(ADDR_W)
    ) u_addr (
        .seg_i (seg_i),
        .off_i (off_i),
        .phys_o(phys)
    );

    lane_wr_steer #(.LANE_W(LANE_W)) u_wsteer (
        .kind_i(wr_kind),
        .data_i(wr_src),
        .bus_o (wr_lanes)
    );

    lane_rd_merge #(.LANE_W(LANE_W)) u_rmerge (
        .kind_i    (rd_kind),
        .odd_i     (r_q.odd),
        .bus_i     (bus_rdata_i),
        .saved_lo_i(r_q.lo),
        .result_o  (rd_result)
    );

    always_comb begin
        split_q = r_q.word && r_q.odd;

        // write lane placement: a fresh request in idle, else the second half of a split
        if (r_q.st == ST_IDLE) begin
            wr_src  = wdata_i;
            wr_kind = !word_i ? LK_BYTE : (phys[0] ? LK_SPLIT_LO : LK_WORD);
        end else begin
            wr_src  = r_q.wd;
            wr_kind = LK_SPLIT_HI;
        end

        rd_kind = !r_q.word ? LK_BYTE : (r_q.odd ? LK_SPLIT_HI : LK_WORD);

        r_d      = r_q;
        r_d.rd   = 1'b0;
        r_d.wr   = 1'b0;
        r_d.done = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.addr  = phys;
                    r_d.odd   = phys[0];
                    r_d.we    = we_i;
                    r_d.word  = word_i;
                    r_d.wd    = wdata_i;
                    r_d.bhe_n = !(word_i || phys[0]);
                    r_d.bwd   = wr_lanes;
                    r_d.rd    = !we_i;
                    r_d.wr    = we_i;
                    r_d.st    = ST_ISSUE1;
                end
            end
            ST_ISSUE1: r_d.st = ST_CAPT1;
            ST_CAPT1: begin
                if (split_q) begin
                    r_d.lo    = bus_rdata_i[DATA_W-1:LANE_W];
                    r_d.addr  = r_q.addr + ADDR_W'(1);
                    r_d.bhe_n = 1'b1;
                    r_d.bwd   = wr_lanes;
                    r_d.rd    = !r_q.we;
                    r_d.wr    = r_q.we;
                    r_d.st    = ST_ISSUE2;
                end else begin
                    r_d.rdata = r_q.we ? '0 : rd_result;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            ST_ISSUE2: r_d.st = ST_CAPT2;
            ST_CAPT2: begin
                r_d.rdata = r_q.we ? '0 : rd_result;
                r_d.done  = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.bhe_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_addr_o  = r_q.addr;
    assign bus_bhe_n_o = r_q.bhe_n;
    assign bus_wdata_o = r_q.bwd;
    assign bus_rd_o    = r_q.rd;
    assign bus_wr_o    = r_q.wr;
    assign done_o      = r_q.done;
    assign rdata_o     = r_q.rdata;
    assign busy_o      = (r_q.st != ST_IDLE);

endmodule

// File: rtl/seg_mem_unit_chk.sv
module seg_mem_unit_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_bhe_n_o,
    input logic              bus_rd_o,
    input logic              bus_wr_o,
    input logic              done_o,
    input logic              busy_o
);
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_o && bus_wr_o)); // R8

    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o || bus_wr_o) |=> !(bus_rd_o || bus_wr_o)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(bus_rd_o || bus_wr_o)); // R6

    AST_ODD_HIGH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd_o || bus_wr_o) && bus_addr_o[0]) |-> !bus_bhe_n_o); // R3

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o || bus_wr_o) |-> busy_o); // R7
endmodule

bind seg_mem_unit seg_mem_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr_o (bus_addr_o),
    .bus_bhe_n_o(bus_bhe_n_o),
    .bus_rd_o   (bus_rd_o),
    .bus_wr_o   (bus_wr_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
);

// File: tb/seg_mem_unit_test.sv
`timescale 1ns/1ps
module seg_mem_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic        word = 1'b0;
    logic [15:0] seg = '0;
    logic [15:0] off = '0;
    logic [15:0] wdata = '0;
    logic [19:0] bus_addr;
    logic        bus_bhe_n;
    logic [15:0] bus_wdata;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_rdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic        busy;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    seg_mem_unit uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .word_i(word),
        .seg_i(seg), .off_i(off), .wdata_i(wdata),
        .bus_addr_o(bus_addr), .bus_bhe_n_o(bus_bhe_n), .bus_wdata_o(bus_wdata),
        .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_rdata_i(bus_rdata),
        .done_o(done), .rdata_o(rdata), .busy_o(busy)
    );

    // two-bank memory model, indexed by address bits 7..1
    logic [7:0] bank_lo [128];
    logic [7:0] bank_hi [128];

    initial begin
        for (int i = 0; i < 128; i++) begin
            bank_lo[i] = 8'((2 * i) ^ 8'h5A);
            bank_hi[i] = 8'((2 * i + 1) ^ 8'hC3);
        end
    end

    always @(posedge clk) begin
        if (bus_wr) begin
            if (!bus_addr[0]) bank_lo[bus_addr[7:1]] <= bus_wdata[7:0];
            if (!bus_bhe_n)   bank_hi[bus_addr[7:1]] <= bus_wdata[15:8];
        end
        if (bus_rd) bus_rdata <= {bank_hi[bus_addr[7:1]], bank_lo[bus_addr[7:1]]};
    end

    // per-access observations
    int          n_stb;
    int          n_wr_stb;
    logic [19:0] s_addr [4];
    logic        s_bhe  [4];
    logic [15:0] s_wd   [4];
    int          done_cyc;
    logic [15:0] res;
    logic        busy_first;
    logic        busy_at_done;
    logic        done_after;

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic wd_sz, input logic [15:0] s,
                          input logic [15:0] o, input logic [15:0] d, input bit inj);
        n_stb = 0; n_wr_stb = 0; done_cyc = 0; res = '0; busy_first = 1'b0; busy_at_done = 1'b1;
        @(negedge clk);
        req = 1'b1; we = w; word = wd_sz; seg = s; off = o; wdata = d;
        for (int k = 1; k <= 20 && done_cyc == 0; k++) begin
            @(negedge clk);
            if (k == 1) begin req = 1'b0; busy_first = busy; end
            if (inj && k == 2) begin
                req = 1'b1; we = 1'b1; word = 1'b0; seg = 16'h0000; off = 16'h0040; wdata = 16'h7777;
            end
            if (inj && k == 3) req = 1'b0;
            if (bus_rd || bus_wr) begin
                if (n_stb < 4) begin
                    s_addr[n_stb] = bus_addr; s_bhe[n_stb] = bus_bhe_n; s_wd[n_stb] = bus_wdata;
                end
                if (bus_wr) n_wr_stb++;
                n_stb++;
            end
            if (done) begin done_cyc = k; res = rdata; busy_at_done = busy; end
        end
        @(negedge clk);
        done_after = done;
    endtask

    task automatic t_reset();
        chk(!bus_rd && !bus_wr, "R9 strobes idle after reset", {bus_rd, bus_wr}, 0);
        chk(!done && !busy, "R9 done/busy low after reset", {done, busy}, 0);
    endtask

    task automatic t_addr_example();
        logic [15:0] exp;
        exp = {8'h00, bank_lo[7'h11]};
        access(1'b0, 1'b0, 16'hA4FB, 16'h4872, 16'h0, 1'b0);
        chk(s_addr[0] == 20'hA9822, "R1 A4FB:4872 address", s_addr[0], 20'hA9822);
        chk(n_stb == 1 && s_bhe[0] == 1'b1, "R2 even byte one cycle, odd bank off", {n_stb[7:0], s_bhe[0]}, {8'd1, 1'b1});
        chk(res == exp, "R2 even byte read result", res, exp);
        chk(done_cyc == 3, "R6 single cycle completion time", done_cyc, 3);
        chk(!done_after, "R6 done lasts one clock", done_after, 0);
        chk(busy_first && !busy_at_done, "R7 busy span", {busy_first, busy_at_done}, 2'b10);
    endtask

    task automatic t_byte_odd_read();
        logic [15:0] exp;
        exp = {8'h00, bank_hi[7'h02]};
        access(1'b0, 1'b0, 16'h0010, 16'h0005, 16'h0, 1'b0);
        chk(s_addr[0] == 20'h00105 && s_bhe[0] == 1'b0, "R3 odd byte address/bank", {s_addr[0], 3'b0, s_bhe[0]}, {20'h00105, 4'h0});
        chk(res == exp, "R3 odd byte read shifted down", res, exp);
    endtask

    task automatic t_byte_writes();
        logic [7:0] hi_before;
        hi_before = bank_hi[7'h18];
        access(1'b1, 1'b0, 16'h0000, 16'h0030, 16'h12A5, 1'b0);
        chk(s_wd[0][7:0] == 8'hA5 && s_bhe[0] == 1'b1, "R2 even byte write lane", {s_wd[0], 3'b0, s_bhe[0]}, {16'hA5A5, 4'h1});
        chk(bank_lo[7'h18] == 8'hA5 && bank_hi[7'h18] == hi_before, "R2 even byte write memory", {bank_hi[7'h18], bank_lo[7'h18]}, {hi_before, 8'hA5});
        chk(n_wr_stb == 1 && res == 16'h0, "R8 write uses write strobe, result zero", {n_wr_stb[15:0], res}, {16'd1, 16'h0});
        access(1'b1, 1'b0, 16'h0000, 16'h0031, 16'h003C, 1'b0);
        chk(s_wd[0][15:8] == 8'h3C && s_bhe[0] == 1'b0, "R3 odd byte write lane", {s_wd[0], 3'b0, s_bhe[0]}, {16'h3C3C, 4'h0});
        chk(bank_hi[7'h18] == 8'h3C && bank_lo[7'h18] == 8'hA5, "R3 odd byte write memory", {bank_hi[7'h18], bank_lo[7'h18]}, 16'h3CA5);
    endtask

    task automatic t_word_even();
        logic [15:0] exp;
        exp = {bank_hi[7'h23], bank_lo[7'h23]};
        access(1'b0, 1'b1, 16'h0100, 16'h0046, 16'h0, 1'b0);
        chk(n_stb == 1 && s_bhe[0] == 1'b0 && s_addr[0] == 20'h01046, "R4 even word one cycle", {n_stb[3:0], s_addr[0], 3'b0, s_bhe[0]}, {4'd1, 20'h01046, 4'h0});
        chk(res == exp, "R4 even word read", res, exp);
        access(1'b1, 1'b1, 16'h0000, 16'h0050, 16'h1234, 1'b0);
        chk(bank_lo[7'h28] == 8'h34 && bank_hi[7'h28] == 8'h12, "R4 even word write little-endian", {bank_hi[7'h28], bank_lo[7'h28]}, 16'h1234);
    endtask

    task automatic t_word_odd_write();
        access(1'b1, 1'b1, 16'h0000, 16'h0021, 16'hBEEF, 1'b0);
        chk(n_stb == 2 && s_addr[0] == 20'h00021 && s_addr[1] == 20'h00022, "R5 split write addresses", {n_stb[7:0], s_addr[0], s_addr[1]}, {8'd2, 20'h00021, 20'h00022});
        chk(s_bhe[0] == 1'b0 && s_bhe[1] == 1'b1, "R5 split write banks", {s_bhe[0], s_bhe[1]}, 2'b01);
        chk(s_wd[0][15:8] == 8'hEF && s_wd[1][7:0] == 8'hBE, "R5 split write lanes", {s_wd[0], s_wd[1]}, {16'hEFEF, 16'hBEBE});
        chk(bank_hi[7'h10] == 8'hEF && bank_lo[7'h11] == 8'hBE, "R5 split write memory", {bank_lo[7'h11], bank_hi[7'h10]}, 16'hBEEF);
        chk(done_cyc == 5, "R6 split completion time", done_cyc, 5);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] exp_old;
        exp_old = {8'h00, bank_lo[7'h20]};
        access(1'b0, 1'b1, 16'h0000, 16'h0021, 16'h0, 1'b1);
        chk(res == 16'hBEEF, "R5 split read reassembly", res, 16'hBEEF);
        chk(n_stb == 2 && n_wr_stb == 0, "R7 request during busy made no cycle", {n_stb[15:0], n_wr_stb[15:0]}, {16'd2, 16'd0});
        chk(!done_after, "R7 no extra completion", done_after, 0);
        access(1'b0, 1'b0, 16'h0000, 16'h0040, 16'h0, 1'b0);
        chk(res == exp_old, "R7 ignored write left memory", res, exp_old);
    endtask

    task automatic t_wrap();
        logic [15:0] exp;
        exp = {bank_lo[7'h00], bank_hi[7'h7F]};
        access(1'b0, 1'b1, 16'hF000, 16'hFFFF, 16'h0, 1'b0);
        chk(s_addr[0] == 20'hFFFFF && s_addr[1] == 20'h00000, "R1 split address wraps", {s_addr[0], s_addr[1]}, {20'hFFFFF, 20'h00000});
        chk(res == exp, "R5 wrapped split read", res, exp);
        access(1'b0, 1'b0, 16'hFFFF, 16'h0010, 16'h0, 1'b0);
        chk(s_addr[0] == 20'h00000, "R1 segment plus offset wraps", s_addr[0], 20'h00000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_example();
        t_byte_odd_read();
        t_byte_writes();
        t_word_even();
        t_word_odd_write();
        t_busy_ignore();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule